// File: doc/BRIEF.md
# Queue-Based Memory-Mapped I/O Bridge

This block is the memory-access stage of a small embedded controller. Each load or store arrives with a base register value, a signed 16-bit offset and, for stores, a data word. The block adds the base and the sign-extended offset to form an effective word address, then sends the access either to a local 512-word scratch RAM or to an I/O region.

In the I/O region, fixed locations act as the ports of two queues that lead to a remote memory device. A remote write takes two stores: the target address goes to one port, then the data goes to another. A remote read is split into two phases. A store to a third port queues the target address. Later, a load from a fourth port takes the returned word from an incoming response queue. A read-only status location reports whether the request queue is full and whether the response queue is empty.

An access that cannot finish yet raises a stall. This happens for a push into a full request queue or a pop from an empty response queue. The pipeline holds the access until the stall clears. Every load returns its data, with a valid strobe, one cycle after it is accepted.

Top module: `mio_bridge`

## Requirements
- R1: The effective address is base plus the sign-extended 16-bit offset. Bit 9 of it selects the I/O region (set) or the scratch RAM (clear). Bits 8:0 give the word index, and higher bits are ignored.
- R2: A store to the scratch RAM writes the word at its index. An accepted load asserts rdata_valid exactly one cycle later, carrying the stored word.
- R3: Stores to I/O words 0, 1 and 2 push onto the request queue with tags 2'b01 (write address), 2'b10 (write data) and 2'b11 (read address). The pushed word is wdata. Entries leave in push order on rq_tag/rq_word, and one leaves on each cycle where rq_valid and rq_ready are both high.
- R4: A store to a push port while the request queue holds RQ_DEPTH entries raises stall and pushes nothing. It completes in the first cycle that starts with free space.
- R5: A load from I/O word 3 pops the oldest response word and returns it. While the response queue is empty, the load raises stall until an entry is present.
- R6: A load from I/O word 4 returns request-queue-full in bit 0 and response-queue-empty in bit 1. All other bits are 0.
- R7: rq_valid is high exactly when the request queue is non-empty. rsp_ready is high exactly when the response queue holds fewer than RSP_DEPTH entries. A response word is taken on a cycle where rsp_valid and rsp_ready are both high.
- R8: After reset, both queues are empty, rdata_valid is low and stall is low when no access is made. A status load therefore returns 2.
- R9: Stores to I/O words 3, 4 and to unmapped I/O words change neither queue. Loads from unmapped I/O words return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A load or store is presented |
| req_we | input | 1 | 1 = store, 0 = load |
| req_base | input | 32 | Base register value |
| req_offset | input | 16 | Signed immediate offset |
| req_wdata | input | 32 | Store data |
| stall | output | 1 | Access cannot complete this cycle; hold it |
| rdata | output | 32 | Load result |
| rdata_valid | output | 1 | rdata holds the result of the load accepted last cycle |
| rq_valid | output | 1 | Request queue head is available |
| rq_ready | input | 1 | Remote side takes the head entry |
| rq_tag | output | 2 | Kind of head entry |
| rq_word | output | 32 | Address or data word of head entry |
| rsp_valid | input | 1 | Remote side offers a read-return word |
| rsp_data | input | 32 | Read-return word |
| rsp_ready | output | 1 | Response queue has room |

## Verification
Checked on every cycle:
- Neither queue is pushed when full or popped when empty, and occupancy never exceeds its depth.
- Any access accepted as a load produces rdata_valid on the next cycle.
- Status results have their upper bits clear.
- Stores aimed at read-only or unmapped I/O words never push.

Only the bench's scenarios can show the rest:
- Data lands at the right effective address, including negative offsets and ignored high bits.
- Tags and words come out in push order.
- Stalls release in the correct cycle once the remote side drains or supplies an entry.
- Response words return in arrival order.

// File: rtl/mio_pkg.sv
package mio_pkg;
  localparam int unsigned DW        = 32;
  localparam int unsigned OFFW      = 16;
  localparam int unsigned IDXW      = 9;
  localparam int unsigned REGION_BIT = IDXW;
  localparam int unsigned TAGW      = 2;

  typedef enum logic [TAGW-1:0] {
    TAG_NONE  = 2'b00,
    TAG_WADDR = 2'b01,
    TAG_WDATA = 2'b10,
    TAG_RADDR = 2'b11
  } rq_tag_e;

  localparam logic [IDXW-1:0] IO_WADDR = 9'd0;
  localparam logic [IDXW-1:0] IO_WDATA = 9'd1;
  localparam logic [IDXW-1:0] IO_RADDR = 9'd2;
  localparam logic [IDXW-1:0] IO_RSP   = 9'd3;
  localparam logic [IDXW-1:0] IO_STAT  = 9'd4;

  // Effective word address, region bit plus index only
  function automatic logic [REGION_BIT:0] eff_word(input logic [DW-1:0] base,
                                                   input logic [OFFW-1:0] off);
    logic [DW-1:0] sum;
    sum = base + {{(DW-OFFW){off[OFFW-1]}}, off};
    return sum[REGION_BIT:0];
  endfunction

  function automatic rq_tag_e port_tag(input logic [IDXW-1:0] sel);
    case (sel)
      IO_WADDR: return TAG_WADDR;
      IO_WDATA: return TAG_WDATA;
      IO_RADDR: return TAG_RADDR;
      default:  return TAG_NONE;
    endcase
  endfunction
endpackage

// File: rtl/mio_fifo.sv
module mio_fifo #(
  parameter int unsigned W     = 34,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] CMAX = CW'(DEPTH);

  logic [W-1:0]  slots [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign full  = (cnt == CMAX);
  assign empty = (cnt == '0);
  assign dout  = slots[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) slots[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  a_r4_push_has_room: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full)
    else $error("push into full queue");
  a_r5_pop_has_data: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty)
    else $error("pop from empty queue");
  a_r7_count_limit: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CMAX)
    else $error("queue occupancy above depth");
endmodule

// File: rtl/mio_scratch.sv
module mio_scratch #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 512
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic                     re,
  input  logic [$clog2(DEPTH)-1:0] addr,
  input  logic [DW-1:0]            wdata,
  output logic [DW-1:0]            rdata
);
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
    if (re) rdata <= cells[addr];
  end
endmodule

// File: rtl/mio_bridge.sv
module mio_bridge
  import mio_pkg::*;
#(
  parameter int unsigned RQ_DEPTH  = 4,
  parameter int unsigned RSP_DEPTH = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_we,
  input  logic [DW-1:0]   req_base,
  input  logic [OFFW-1:0] req_offset,
  input  logic [DW-1:0]   req_wdata,
  output logic            stall,
  output logic [DW-1:0]   rdata,
  output logic            rdata_valid,
  output logic            rq_valid,
  input  logic            rq_ready,
  output logic [TAGW-1:0] rq_tag,
  output logic [DW-1:0]   rq_word,
  input  logic            rsp_valid,
  input  logic [DW-1:0]   rsp_data,
  output logic            rsp_ready
);
  localparam int unsigned RQW = TAGW + DW;
  localparam int unsigned SCRATCH_WORDS = 1 << IDXW;

  typedef enum logic {SRC_RAM, SRC_SIDE} ld_src_e;

  // Decode events brought out as named wires
  logic [REGION_BIT:0] ea;
  logic [IDXW-1:0]     idx;
  logic is_io, is_push_port, ld_pop, ld_stat;
  logic rq_full, rq_empty, rsp_full, rsp_empty;
  logic go, rq_push, rq_pop, rsp_push, rsp_pop, ram_we, ram_re;
  logic [RQW-1:0] rq_head;
  logic [DW-1:0]  rsp_head, ram_q, side_q;
  ld_src_e        src_q;
  logic           stat_q;
  rq_tag_e        push_tag;

  assign ea           = eff_word(req_base, req_offset);
  assign idx          = ea[IDXW-1:0];
  assign is_io        = ea[REGION_BIT];
  assign push_tag     = port_tag(idx);
  assign is_push_port = is_io && req_we && (push_tag != TAG_NONE);
  assign ld_pop       = is_io && !req_we && (idx == IO_RSP);
  assign ld_stat      = is_io && !req_we && (idx == IO_STAT);

  assign stall = req_valid && ((is_push_port && rq_full) || (ld_pop && rsp_empty));
  assign go    = req_valid && !stall;

  assign rq_push  = go && is_push_port;
  assign rq_pop   = rq_valid && rq_ready;
  assign rsp_push = rsp_valid && rsp_ready;
  assign rsp_pop  = go && ld_pop;
  assign ram_we   = go && req_we && !is_io;
  assign ram_re   = go && !req_we && !is_io;

  mio_fifo #(.W(RQW), .DEPTH(RQ_DEPTH)) u_rq_fifo (
    .clk(clk), .rst_n(rst_n), .push(rq_push), .din({push_tag, req_wdata}),
    .pop(rq_pop), .dout(rq_head), .full(rq_full), .empty(rq_empty)
  );

  mio_fifo #(.W(DW), .DEPTH(RSP_DEPTH)) u_rsp_fifo (
    .clk(clk), .rst_n(rst_n), .push(rsp_push), .din(rsp_data),
    .pop(rsp_pop), .dout(rsp_head), .full(rsp_full), .empty(rsp_empty)
  );

  mio_scratch #(.DW(DW), .DEPTH(SCRATCH_WORDS)) u_scratch (
    .clk(clk), .we(ram_we), .re(ram_re), .addr(idx), .wdata(req_wdata), .rdata(ram_q)
  );

  assign rq_valid  = !rq_empty;
  assign rq_tag    = rq_head[RQW-1:DW];
  assign rq_word   = rq_head[DW-1:0];
  assign rsp_ready = !rsp_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_valid <= 1'b0;
      src_q       <= SRC_SIDE;
      side_q      <= '0;
      stat_q      <= 1'b0;
    end else begin
      rdata_valid <= go && !req_we;
      if (go && !req_we) begin
        src_q  <= is_io ? SRC_SIDE : SRC_RAM;
        stat_q <= ld_stat;
        if (ld_pop)       side_q <= rsp_head;
        else if (ld_stat) side_q <= {{(DW-2){1'b0}}, rsp_empty, rq_full};
        else              side_q <= '0;
      end
    end
  end

  assign rdata = (src_q == SRC_RAM) ? ram_q : side_q;

  a_r2_load_answers: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !req_we) |=> rdata_valid) else $error("accepted load gave no result");
  a_r6_status_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata_valid && stat_q) |-> (rdata[DW-1:2] == '0)) else $error("status upper bits set");
  a_r9_readonly_no_push: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_we && is_io && idx > IO_RADDR) |-> !rq_push)
    else $error("push from a non-push location");
  a_r4_stall_blocks_push: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_we && rq_full) |-> !rq_push) else $error("push while queue full");
endmodule

// File: tb/test_mio_bridge.sv
`timescale 1ns/100ps
module test_mio_bridge;
  localparam int RQD = 4;
  localparam int RSD = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_we = 0, rq_ready = 0, rsp_valid = 0;
  logic [31:0] req_base = 0, req_wdata = 0, rsp_data = 0;
  logic [15:0] req_offset = 0;
  logic stall, rdata_valid, rq_valid, rsp_ready;
  logic [31:0] rdata, rq_word;
  logic [1:0] rq_tag;

  always #2.5 clk = ~clk;

  mio_bridge i_mio_bridge (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
    .req_base(req_base), .req_offset(req_offset), .req_wdata(req_wdata),
    .stall(stall), .rdata(rdata), .rdata_valid(rdata_valid),
    .rq_valid(rq_valid), .rq_ready(rq_ready), .rq_tag(rq_tag), .rq_word(rq_word),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_ready(rsp_ready)
  );

  // Behavioural reference model
  logic [33:0] m_rq[$];
  logic [31:0] m_rsp[$];
  logic [31:0] m_mem [512];
  logic        exp_rdv = 0;
  logic [31:0] exp_rdata = 0;
  string       rd_tag = "R2";
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int ea_of();
    int s;
    s = int'(req_base) + int'($signed(req_offset));
    return s & 32'h3FF;
  endfunction

  function automatic bit m_stall();
    int a, sel;
    bit io;
    a = ea_of(); io = a >= 512; sel = a % 512;
    if (!req_valid || !io) return 0;
    if (req_we && sel <= 2 && m_rq.size() == RQD) return 1;
    if (!req_we && sel == 3 && m_rsp.size() == 0) return 1;
    return 0;
  endfunction

  bit exp_stall = 0;

  always @(negedge clk) if (rst_n && !done) begin
    exp_stall = m_stall();
    chk(req_we ? "R4" : "R5", stall, exp_stall);
    chk("R7", rq_valid, m_rq.size() != 0);
    if (m_rq.size() != 0) chk("R3", {rq_tag, rq_word}, m_rq[0]);
    chk("R7", rsp_ready, m_rsp.size() < RSD);
    chk("R2", rdata_valid, exp_rdv);
    if (exp_rdv) chk(rd_tag, rdata, exp_rdata);
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rq.delete(); m_rsp.delete(); exp_rdv = 0;
    end else begin
      int a, sel, rq_n, rsp_n;
      bit st, io;
      st = m_stall(); rq_n = m_rq.size(); rsp_n = m_rsp.size();
      a = ea_of(); io = a >= 512; sel = a % 512;
      exp_rdv = 0;
      if (rq_ready && rq_n > 0) void'(m_rq.pop_front());
      if (req_valid && !st) begin
        if (!io) begin
          if (req_we) m_mem[sel] = req_wdata;
          else begin exp_rdv = 1; exp_rdata = m_mem[sel]; rd_tag = "R1/R2"; end
        end else if (req_we) begin
          if (sel <= 2) m_rq.push_back({2'(sel + 1), req_wdata});
        end else begin
          exp_rdv = 1;
          if (sel == 3) begin exp_rdata = m_rsp.pop_front(); rd_tag = "R5"; end
          else if (sel == 4) begin
            exp_rdata = {30'd0, rsp_n == 0, rq_n == RQD}; rd_tag = "R6";
          end else begin exp_rdata = 0; rd_tag = "R9"; end
        end
      end
      if (rsp_valid && rsp_n < RSD) m_rsp.push_back(rsp_data);
    end
  end

  task automatic op(bit we, logic [31:0] base, logic [15:0] off, logic [31:0] wd);
    req_valid = 1; req_we = we; req_base = base; req_offset = off; req_wdata = wd;
    forever begin
      @(negedge clk); #1;
      if (!exp_stall) break;
    end
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  localparam logic [31:0] IO = 32'h200;

  initial begin
    int cyc = 0;
    fork
      begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk("R8", {stall, rq_valid, rdata_valid, rsp_ready}, 4'b0001);
        @(posedge clk); #1;
        op(0, IO, 16'd4, 0);                       // R8 status after reset = 2
        @(posedge clk); #1;
        // R1/R2 scratch, high bits ignored, negative offsets
        op(1, 32'h0000_0400, 16'd5, 32'hA5A5_0005);
        op(1, 32'h0000_0010, 16'hFFFC, 32'h1234_000C);
        op(1, 32'h0000_01FF, 16'd0, 32'hDEAD_01FF);
        op(0, 32'h0, 16'd5, 0);
        op(0, 32'h0000_000C, 16'd0, 0);
        op(0, 32'h0001_0000, 16'h01FF, 0);
        // R3 and R4: fill request queue with remote side blocked
        op(1, IO, 16'd0, 32'h0000_1000);
        op(1, IO, 16'd1, 32'hCAFE_0001);
        op(1, IO, 16'd2, 32'h0000_2000);
        op(1, IO + 2, 16'd0, 32'h0000_3000);
        op(0, IO, 16'd4, 0);                       // R6 full bit
        fork
          op(1, IO, 16'd1, 32'hBEEF_0002);         // R4 stalls
          begin repeat (3) @(posedge clk); #1 rq_ready = 1; end
        join
        repeat (6) @(posedge clk); #1;
        @(negedge clk); chk("R3", rq_valid, 1'b0);
        // R5: pop on empty stalls until data arrives
        fork
          op(0, IO, 16'd3, 0);
          begin
            repeat (3) @(posedge clk); #1 rsp_valid = 1; rsp_data = 32'h5151_0001;
            @(posedge clk); #1 rsp_valid = 0;
          end
        join
        // R7: overfill response queue
        @(posedge clk); #1 rsp_valid = 1;
        for (int k = 0; k < 6; k++) begin rsp_data = 32'h7000_0000 + k; @(posedge clk); #1; end
        rsp_valid = 0;
        @(negedge clk); chk("R7", rsp_ready, 1'b0);
        @(posedge clk); #1;
        op(0, IO, 16'd4, 0);                       // R6 empty bit clear
        for (int k = 0; k < 4; k++) op(0, IO, 16'd3, 0);
        // R9: read-only and unmapped stores have no effect
        op(1, IO, 16'd3, 32'h1);
        op(1, IO, 16'd4, 32'h2);
        op(1, IO, 16'd100, 32'h3);
        @(negedge clk); chk("R9", rq_valid, 1'b0);
        @(posedge clk); #1;
        op(0, IO, 16'd100, 0);
        op(0, IO, 16'd4, 0);
        repeat (3) @(posedge clk);
      end
      begin
        while (cyc < 20000) begin @(posedge clk); cyc++; end
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule